// File: doc/BRIEF.md
# Secure-State Coprocessor Access Control Register

This block holds a 32-bit privileged configuration word. Secure software writes it to decide which coprocessor and system resources Non-secure software may reach. It sits beside a coprocessor-register access port. Each access on that port carries a valid strobe, a read/write flag, the current security state, the privilege level, a 3-bit target code and write data.

From the stored word, the block produces several outputs. It drives per-resource permit signals and a same-cycle undefined-instruction trap request for disallowed accesses. It drives a write-enable mask that a companion auxiliary control register applies to Non-secure writes. It also drives force signals that pin two companion access-control disable bits to 1 while Non-secure code runs.

Storage is built only for implemented fields. A build-time option removes the preload-engine permission field.

Top module: `cpac_reg`

## Requirements
- R1: A synchronous active-high reset clears every implemented field to 0. After reset, a Secure privileged read of the register returns 0 and every permit, enable and force output is 0.
- R2: Any access to target code 0 (this register) made while `acc_priv` is 0 asserts `undef_trap` in the cycle of the strobe. The register keeps its value, and `acc_rdata` stays 0.
- R3: A privileged Secure write to target code 0 loads the implemented fields from `acc_wdata` at the next clock edge. A Non-secure write to target code 0 changes nothing and raises no trap.
- R4: Bits [31:19], [13:12] and [9:0] are reserved: they read as 0 whatever was written. A privileged read of target code 0 returns the stored word on `acc_rdata` in the cycle of the strobe. Every other access returns 0.
- R5: Bit 10 drives `cp10_ns_ok` and bit 11 drives `cp11_ns_ok`. A Non-secure access to target code 1 (coprocessor 10) or target code 2 (coprocessor 11) whose bit is 0 asserts `undef_trap`. Secure accesses to these targets never trap.
- R6: Bit 18 governs the auxiliary control register. When it is 0, a Non-secure write to target code 3 traps and `aux_ns_wmask` is all zeros. When it is 1, there is no trap, and `aux_ns_wmask` has only bit `SMP_BIT` (default 6) set.
- R7: Bit 17 drives `tlb_lock_ns_en`, which permits lockable TLB entries to be allocated in Non-secure state.
- R8: With the preload engine present, bit 16 drives `ple_ns_ok`. A Non-secure access to target code 4 (the preload-engine register group) traps while bit 16 is 0.
- R9: With `HAS_PRELOAD` = 0, bit 16 reads as 0 and ignores writes. Every Non-secure access to target code 4 then traps.
- R10: Bit 15 drives `force_simd_dis` and bit 14 drives `force_upper_dis`. These are the force-to-1 requests for the companion Advanced SIMD disable bit and the D16-D31 register-file disable bit.
- R11: Target codes 5 (debug coprocessor), 6 (system-control coprocessor) and 7 (other) never trap, whatever the register holds. `undef_trap` is 0 whenever `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ns | input | 1 | 1 = Non-secure state |
| acc_priv | input | 1 | 1 = privileged mode |
| acc_tgt | input | 3 | Target code (see R2, R5, R6, R8, R11) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for target code 0 |
| undef_trap | output | 1 | Undefined-instruction trap request |
| cp10_ns_ok | output | 1 | Non-secure coprocessor 10 permitted |
| cp11_ns_ok | output | 1 | Non-secure coprocessor 11 permitted |
| ple_ns_ok | output | 1 | Non-secure preload-engine group permitted |
| tlb_lock_ns_en | output | 1 | Non-secure lockable TLB allocation enable |
| aux_ns_wmask | output | 32 | Non-secure write mask for the auxiliary control register |
| force_simd_dis | output | 1 | Force companion SIMD disable bit to 1 |
| force_upper_dis | output | 1 | Force companion D16-D31 disable bit to 1 |

## Verification
Two situations are hard to bring about from the ports.

The first is an ignored write. A Non-secure or unprivileged write leaves no trace on any output. The stimulus therefore first loads a known non-zero pattern through a Secure write, then issues the rejected write. It then reads the register back with a Secure privileged read before any other access.

The second is the build without a preload engine. It cannot be reached by any input sequence, so the bench drives a second instance built with that option from the same stimulus. It checks that instance's read-back and trap separately.

// File: rtl/cpac_pkg.sv
package cpac_pkg;

   localparam int unsigned CPAC_W    = 32;
   localparam int unsigned POS_CP10  = 10;
   localparam int unsigned POS_CP11  = 11;
   localparam int unsigned POS_UPPER = 14;
   localparam int unsigned POS_SIMD  = 15;
   localparam int unsigned POS_PLE   = 16;
   localparam int unsigned POS_TLB   = 17;
   localparam int unsigned POS_AUX   = 18;

   typedef enum logic [2:0] {
      TGT_CTRL   = 3'd0,
      TGT_CP10   = 3'd1,
      TGT_CP11   = 3'd2,
      TGT_AUX    = 3'd3,
      TGT_PLE    = 3'd4,
      TGT_DEBUG  = 3'd5,
      TGT_SYSCTL = 3'd6,
      TGT_OTHER  = 3'd7
   } cpac_tgt_e;

   function automatic logic [CPAC_W-1:0] impl_mask(input bit has_ple);
      logic [CPAC_W-1:0] m;
      m = '0;
      m[POS_CP10]  = 1'b1;
      m[POS_CP11]  = 1'b1;
      m[POS_UPPER] = 1'b1;
      m[POS_SIMD]  = 1'b1;
      m[POS_PLE]   = has_ple;
      m[POS_TLB]   = 1'b1;
      m[POS_AUX]   = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cpac_store.sv
module cpac_store
   import cpac_pkg::*;
#(
   parameter int unsigned          W    = CPAC_W,
   parameter logic [CPAC_W-1:0]    MASK = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_flop
         logic b_q;
         always_ff @(posedge clk) begin
            if (rst)        b_q <= 1'b0;
            else if (wr_en) b_q <= wdata[i];
         end
         assign q[i] = b_q;
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/cpac_gate.sv
module cpac_gate
   import cpac_pkg::*;
(
   input  logic              valid,
   input  logic              write,
   input  logic              ns,
   input  logic              priv,
   input  cpac_tgt_e         tgt,
   input  logic [CPAC_W-1:0] cfg,
   output logic              trap,
   output logic              wr_en,
   output logic              rd_en
);

   logic deny;

   always_comb begin
      deny = 1'b0;
      unique case (tgt)
         TGT_CTRL:   deny = !priv;
         TGT_CP10:   deny = ns && !cfg[POS_CP10];
         TGT_CP11:   deny = ns && !cfg[POS_CP11];
         TGT_AUX:    deny = ns && write && !cfg[POS_AUX];
         TGT_PLE:    deny = ns && !cfg[POS_PLE];
         default:    deny = 1'b0;
      endcase
   end

   assign trap  = valid && deny;
   assign wr_en = valid && write && priv && !ns && (tgt == TGT_CTRL);
   assign rd_en = valid && !write && priv && (tgt == TGT_CTRL);

endmodule

// File: rtl/cpac_companion.sv
module cpac_companion
   import cpac_pkg::*;
#(
   parameter int unsigned SMP_BIT = 6
) (
   input  logic [CPAC_W-1:0] cfg,
   output logic              cp10_ok,
   output logic              cp11_ok,
   output logic              ple_ok,
   output logic              tlb_en,
   output logic [CPAC_W-1:0] aux_wmask,
   output logic              simd_force,
   output logic              upper_force
);

   localparam logic [CPAC_W-1:0] SMP_ONEHOT = CPAC_W'(1) << SMP_BIT;

   assign cp10_ok     = cfg[POS_CP10];
   assign cp11_ok     = cfg[POS_CP11];
   assign ple_ok      = cfg[POS_PLE];
   assign tlb_en      = cfg[POS_TLB];
   assign aux_wmask   = cfg[POS_AUX] ? SMP_ONEHOT : '0;
   assign simd_force  = cfg[POS_SIMD];
   assign upper_force = cfg[POS_UPPER];

endmodule

// File: rtl/cpac_reg.sv
module cpac_reg
   import cpac_pkg::*;
#(
   parameter int unsigned REG_W       = 32,
   parameter bit          HAS_PRELOAD = 1'b1,
   parameter int unsigned SMP_BIT     = 6
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        acc_valid,
   input  logic        acc_write,
   input  logic        acc_ns,
   input  logic        acc_priv,
   input  logic [2:0]  acc_tgt,
   input  logic [31:0] acc_wdata,
   output logic [31:0] acc_rdata,
   output logic        undef_trap,
   output logic        cp10_ns_ok,
   output logic        cp11_ns_ok,
   output logic        ple_ns_ok,
   output logic        tlb_lock_ns_en,
   output logic [31:0] aux_ns_wmask,
   output logic        force_simd_dis,
   output logic        force_upper_dis
);

   localparam logic [CPAC_W-1:0] IMPL = impl_mask(HAS_PRELOAD);

   if (REG_W != CPAC_W) begin : g_bad_width
      $error("cpac_reg: REG_W must equal 32");
   end
   if (SMP_BIT >= REG_W) begin : g_bad_smp
      $error("cpac_reg: SMP_BIT out of range");
   end

   logic [CPAC_W-1:0] cfg_q;
   logic [CPAC_W-1:0] impl_w;
   logic              wr_en;
   logic              rd_en;
   cpac_tgt_e         tgt_e;

   assign impl_w = IMPL;
   assign tgt_e  = cpac_tgt_e'(acc_tgt);

   cpac_store #(.W(CPAC_W), .MASK(IMPL)) u_store (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en),
      .wdata (acc_wdata),
      .q     (cfg_q)
   );

   cpac_gate u_gate (
      .valid (acc_valid),
      .write (acc_write),
      .ns    (acc_ns),
      .priv  (acc_priv),
      .tgt   (tgt_e),
      .cfg   (cfg_q),
      .trap  (undef_trap),
      .wr_en (wr_en),
      .rd_en (rd_en)
   );

   cpac_companion #(.SMP_BIT(SMP_BIT)) u_comp (
      .cfg         (cfg_q),
      .cp10_ok     (cp10_ns_ok),
      .cp11_ok     (cp11_ns_ok),
      .ple_ok      (ple_ns_ok),
      .tlb_en      (tlb_lock_ns_en),
      .aux_wmask   (aux_ns_wmask),
      .simd_force  (force_simd_dis),
      .upper_force (force_upper_dis)
   );

   assign acc_rdata = rd_en ? (cfg_q & IMPL) : '0;

endmodule

// File: rtl/cpac_reg_chk.sv
module cpac_reg_chk (
   input logic        clk,
   input logic        rst,
   input logic        valid,
   input logic        write,
   input logic        ns,
   input logic        priv,
   input logic [2:0]  tgt,
   input logic [31:0] wdata,
   input logic [31:0] cfg,
   input logic [31:0] impl,
   input logic [31:0] rdata,
   input logic        trap,
   input logic [31:0] aux_wmask
);

   a_r2_unpriv_trap: assert property (@(posedge clk) disable iff (rst)
      valid && !priv && tgt == 3'd0 |-> trap);

   a_r2_unpriv_hold: assert property (@(posedge clk) disable iff (rst)
      valid && !priv && tgt == 3'd0 |=> $stable(cfg));

   a_r3_ns_write_ignored: assert property (@(posedge clk) disable iff (rst)
      valid && write && ns && tgt == 3'd0 |=> $stable(cfg));

   a_r3_secure_write: assert property (@(posedge clk) disable iff (rst)
      valid && write && !ns && priv && tgt == 3'd0 |=> cfg == ($past(wdata) & impl));

   a_r4_rdata_reserved: assert property (@(posedge clk) disable iff (rst)
      (rdata & ~impl) == 32'd0);

   a_r5_cp10_trap: assert property (@(posedge clk) disable iff (rst)
      valid && ns && tgt == 3'd1 && !cfg[10] |-> trap);

   a_r6_aux_mask: assert property (@(posedge clk) disable iff (rst)
      $countones(aux_wmask) <= 1);

   a_r11_trap_needs_strobe: assert property (@(posedge clk) disable iff (rst)
      !valid |-> !trap);

   a_r11_secure_quiet: assert property (@(posedge clk) disable iff (rst)
      valid && !ns && tgt != 3'd0 |-> !trap);

endmodule

bind cpac_reg cpac_reg_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .valid     (acc_valid),
   .write     (acc_write),
   .ns        (acc_ns),
   .priv      (acc_priv),
   .tgt       (acc_tgt),
   .wdata     (acc_wdata),
   .cfg       (cfg_q),
   .impl      (impl_w),
   .rdata     (acc_rdata),
   .trap      (undef_trap),
   .aux_wmask (aux_ns_wmask)
);

// File: tb/tb_cpac_reg.sv
module tb_cpac_reg;

   localparam logic [31:0] MASK_FULL = 32'h0007_CC00;
   localparam logic [31:0] MASK_NOPL = 32'h0006_CC00;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic        acc_ns = 1'b0;
   logic        acc_priv = 1'b0;
   logic [2:0]  acc_tgt = 3'd0;
   logic [31:0] acc_wdata = '0;

   logic [31:0] rdata, rdata_np, aux_m, aux_m_np;
   logic trap, trap_np, c10, c11, ple, tlb, fs, fu;
   logic c10_np, c11_np, ple_np, tlb_np, fs_np, fu_np;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cpac_reg dut (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_ns(acc_ns), .acc_priv(acc_priv), .acc_tgt(acc_tgt), .acc_wdata(acc_wdata),
      .acc_rdata(rdata), .undef_trap(trap), .cp10_ns_ok(c10), .cp11_ns_ok(c11),
      .ple_ns_ok(ple), .tlb_lock_ns_en(tlb), .aux_ns_wmask(aux_m),
      .force_simd_dis(fs), .force_upper_dis(fu)
   );

   cpac_reg #(.HAS_PRELOAD(1'b0)) dut_np (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_ns(acc_ns), .acc_priv(acc_priv), .acc_tgt(acc_tgt), .acc_wdata(acc_wdata),
      .acc_rdata(rdata_np), .undef_trap(trap_np), .cp10_ns_ok(c10_np), .cp11_ns_ok(c11_np),
      .ple_ns_ok(ple_np), .tlb_lock_ns_en(tlb_np), .aux_ns_wmask(aux_m_np),
      .force_simd_dis(fs_np), .force_upper_dis(fu_np)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One access: drive at negedge, sample mid-low-phase, release after the edge.
   task automatic access(input bit ns, input bit priv, input bit wr, input logic [2:0] tgt,
                         input logic [31:0] wd, output logic tr, output logic [31:0] rd,
                         output logic tr_np, output logic [31:0] rd_np);
      @(negedge clk);
      acc_valid = 1'b1; acc_ns = ns; acc_priv = priv; acc_write = wr;
      acc_tgt = tgt; acc_wdata = wd;
      #5;
      tr = trap; rd = rdata; tr_np = trap_np; rd_np = rdata_np;
      @(posedge clk);
      #1;
      acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
   endtask

   task automatic sec_write(input logic [31:0] wd);
      logic t, tn;
      logic [31:0] r, rn;
      access(1'b0, 1'b1, 1'b1, 3'd0, wd, t, r, tn, rn);
   endtask

   task automatic sec_read(output logic [31:0] rd, output logic [31:0] rd_np);
      logic t, tn;
      access(1'b0, 1'b1, 1'b0, 3'd0, '0, t, rd, tn, rd_np);
   endtask

   task automatic t_reset();
      logic [31:0] r, rn;
      sec_read(r, rn);
      chk("R1 reset read", r, 32'd0);
      #5;
      chk("R1 reset outputs", {c10, c11, ple, tlb, fs, fu}, 32'd0);
      chk("R1 reset aux mask", aux_m, 32'd0);
   endtask

   task automatic t_secure_write_reserved();
      logic [31:0] r, rn;
      sec_write(32'hFFFF_FFFF);
      sec_read(r, rn);
      chk("R3 secure write loads fields", r & MASK_FULL, MASK_FULL);
      chk("R4 reserved bits read zero", r, MASK_FULL);
      sec_write(32'h0000_4C00);
      sec_read(r, rn);
      chk("R4 pattern read back", r, 32'h0000_4C00);
   endtask

   task automatic t_ns_write_ignored();
      logic t, tn;
      logic [31:0] r, rn;
      sec_write(32'h0005_0400);
      access(1'b1, 1'b1, 1'b1, 3'd0, 32'h0000_0000, t, r, tn, rn);
      chk("R3 NS write no trap", {31'd0, t}, 32'd0);
      sec_read(r, rn);
      chk("R3 NS write ignored", r, 32'h0005_0400);
      access(1'b1, 1'b1, 1'b0, 3'd0, '0, t, r, tn, rn);
      chk("R4 NS privileged read", r, 32'h0005_0400);
   endtask

   task automatic t_unpriv();
      logic t, tn;
      logic [31:0] r, rn;
      sec_write(32'h0002_0800);
      access(1'b0, 1'b0, 1'b1, 3'd0, 32'hFFFF_FFFF, t, r, tn, rn);
      chk("R2 unpriv write traps", {31'd0, t}, 32'd1);
      sec_read(r, rn);
      chk("R2 unpriv write ignored", r, 32'h0002_0800);
      access(1'b1, 1'b0, 1'b0, 3'd0, '0, t, r, tn, rn);
      chk("R2 unpriv read traps", {31'd0, t}, 32'd1);
      chk("R2 unpriv read data zero", r, 32'd0);
   endtask

   task automatic t_cp_permits();
      logic t, tn;
      logic [31:0] r, rn;
      sec_write(32'h0000_0400);
      #5;
      chk("R5 permit outputs", {30'd0, c11, c10}, 32'd1);
      access(1'b1, 1'b0, 1'b0, 3'd1, '0, t, r, tn, rn);
      chk("R5 NS cp10 allowed", {31'd0, t}, 32'd0);
      access(1'b1, 1'b0, 1'b0, 3'd2, '0, t, r, tn, rn);
      chk("R5 NS cp11 traps", {31'd0, t}, 32'd1);
      access(1'b0, 1'b0, 1'b0, 3'd2, '0, t, r, tn, rn);
      chk("R5 secure cp11 no trap", {31'd0, t}, 32'd0);
      sec_write(32'h0000_0800);
      access(1'b1, 1'b0, 1'b0, 3'd1, '0, t, r, tn, rn);
      chk("R5 NS cp10 traps", {31'd0, t}, 32'd1);
   endtask

   task automatic t_aux();
      logic t, tn;
      logic [31:0] r, rn;
      sec_write(32'h0000_0000);
      access(1'b1, 1'b1, 1'b1, 3'd3, 32'hFFFF_FFFF, t, r, tn, rn);
      chk("R6 NS aux write traps", {31'd0, t}, 32'd1);
      chk("R6 mask zero", aux_m, 32'd0);
      access(1'b1, 1'b1, 1'b0, 3'd3, '0, t, r, tn, rn);
      chk("R6 NS aux read no trap", {31'd0, t}, 32'd0);
      sec_write(32'h0004_0000);
      access(1'b1, 1'b1, 1'b1, 3'd3, 32'hFFFF_FFFF, t, r, tn, rn);
      chk("R6 NS aux write allowed", {31'd0, t}, 32'd0);
      chk("R6 mask SMP only", aux_m, 32'h0000_0040);
   endtask

   task automatic t_tlb_force();
      sec_write(32'h0002_0000);
      #5;
      chk("R7 tlb enable", {29'd0, tlb, fs, fu}, 32'h4);
      sec_write(32'h0000_8000);
      #5;
      chk("R10 simd force", {29'd0, tlb, fs, fu}, 32'h2);
      sec_write(32'h0000_4000);
      #5;
      chk("R10 upper force", {29'd0, tlb, fs, fu}, 32'h1);
   endtask

   task automatic t_preload();
      logic t, tn;
      logic [31:0] r, rn;
      sec_write(32'h0000_0000);
      access(1'b1, 1'b1, 1'b0, 3'd4, '0, t, r, tn, rn);
      chk("R8 NS preload traps", {31'd0, t}, 32'd1);
      sec_write(32'h0001_0000);
      #5;
      chk("R8 ple permit", {31'd0, ple}, 32'd1);
      access(1'b1, 1'b1, 1'b0, 3'd4, '0, t, r, tn, rn);
      chk("R8 NS preload allowed", {31'd0, t}, 32'd0);
      chk("R9 absent preload traps", {31'd0, tn}, 32'd1);
      sec_write(32'hFFFF_FFFF);
      sec_read(r, rn);
      chk("R9 absent bit reads zero", rn, MASK_NOPL);
      chk("R9 absent permit low", {31'd0, ple_np}, 32'd0);
   endtask

   task automatic t_unaffected();
      logic t, tn;
      logic [31:0] r, rn;
      sec_write(32'h0000_0000);
      for (int k = 5; k < 8; k++) begin
         access(1'b1, 1'b0, 1'b1, 3'(k), 32'hFFFF_FFFF, t, r, tn, rn);
         chk("R11 target never traps", {31'd0, t}, 32'd0);
      end
      @(negedge clk);
      #5;
      chk("R11 idle no trap", {31'd0, trap}, 32'd0);
   endtask

   task automatic t_sync_reset();
      logic [31:0] r, rn;
      sec_write(32'hFFFF_FFFF);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      sec_read(r, rn);
      chk("R1 mid-run reset clears", r, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_secure_write_reserved();
      t_ns_write_ignored();
      t_unpriv();
      t_cp_permits();
      t_aux();
      t_tlb_force();
      t_preload();
      t_unaffected();
      t_sync_reset();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule